// File: doc/BRIEF.md
# SECDED Protected Word Memory

This block is a word-wide memory slave on a parallel bus. A requester presents a word address, a direction and, for writes, 16 data bits; when the address falls inside the window that the block serves, the block answers one cycle later with an acknowledge and, for reads, the data. Each word is kept as a 22-bit codeword: the 16 data bits, a 5-bit Hamming check field and one overall parity bit. On every read the codeword is checked. A single flipped bit is repaired before the data leaves the block. Two flipped bits are detected and reported.

The window starts at a selectable base, chosen on boundaries of 8192 words (16K bytes), anywhere in a 20-bit word address space. Requests outside the window are not answered, so the requester's own timeout handles them. Two sticky indicators, one for repaired errors and one for unrepairable errors, stay set until a clear pulse. An interrupt request rises only for unrepairable errors and stays high until acknowledged. A test input XORs a chosen mask into the codeword as it is stored, which makes it possible to plant faults. Full size is 32768 words (`WORDS_LOG2 = 15`). The default is smaller to keep elaboration light.

Top module: `ecc_mem_ctrl`

## Requirements
- R1: A request with `req` high whose address is in the window is acknowledged by `ack` high in the next cycle. A read returns in that cycle on `rdata` the 16 bits most recently written to that word, when the stored codeword carries no injected flip.
- R2: An address is in the window when `(addr - baseSel*8192) mod 2^20 < 2^WORDS_LOG2`. The word index is that difference. Any other request gets no `ack` and leaves the memory unchanged.
- R3: On a write, bit i of `flipMask` inverts bit i of the stored 22-bit codeword. A read of a word with exactly one inverted bit, in any of the 22 positions, returns the original data and sets `ceFlag` one cycle after the `ack`.
- R4: A read of a word with exactly two inverted bits sets `ueFlag` and `irq` one cycle after the `ack`, and leaves `ceFlag` unchanged.
- R5: `ceFlag` and `ueFlag` stay high until a cycle with `clr` high. `clr` does not affect `irq`. When a new error report and `clr` arrive in the same cycle, the flag is set.
- R6: `irq` stays high until a cycle with `irqAck` high. An unrepairable error reported in the same cycle as `irqAck` keeps `irq` high.
- R7: After reset, `ack`, `ceFlag`, `ueFlag` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baseSel | input | ADDR_W-WIN_LOG2 (7) | Window start in units of 8192 words |
| req | input | 1 | Request valid this cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W (20) | Word address |
| wdata | input | 16 | Write data |
| flipMask | input | 22 | Test mask XORed into the stored codeword |
| clr | input | 1 | Clears both sticky indicators |
| irqAck | input | 1 | Drops the interrupt request |
| ack | output | 1 | Request accepted (one cycle after `req`) |
| rdata | output | 16 | Read data, corrected, valid with `ack` on reads |
| ceFlag | output | 1 | Sticky repaired-error indicator |
| ueFlag | output | 1 | Sticky unrepairable-error indicator |
| irq | output | 1 | Interrupt request for unrepairable errors |

## Verification
The bench builds the block with `ADDR_W = 20`, `WIN_LOG2 = 13` and `WORDS_LOG2 = 10`. With these values the window is smaller than one base step, so addresses just past the window end and just below its start are cheap to reach. Moving the base to its top value of 127 puts the window at the very end of the address space. A single-bit mask is planted in every one of the 22 codeword positions, and several two-bit masks are planted as well. Clear and acknowledge pulses are placed in the same cycle as fresh error reports, to exercise the case where setting wins.

// File: rtl/ecc_mem_pkg.sv
package ecc_mem_pkg;

  localparam int DATA_W = 16;
  localparam int CW_W   = 22;
  localparam int SYN_W  = 5;

  typedef struct packed {
    logic wrEn;
    logic rdEn;
  } ctrlStrobes_t;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              corr;
    logic              unc;
  } decodeRes_t;

  // Codeword bit 0 is overall parity; bits 1..21 are Hamming positions,
  // with check bits at powers of two and data bits filling the rest.
  function automatic logic [CW_W-1:0] eccEncode(input logic [DATA_W-1:0] d);
    logic [CW_W-1:0] cw;
    logic            acc;
    int              n;
    cw = '0;
    n  = 0;
    for (int p = 1; p < CW_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        cw[p] = d[n];
        n++;
      end
    end
    for (int k = 0; k < SYN_W; k++) begin
      acc = 1'b0;
      for (int p = 1; p < CW_W; p++) begin
        if (((p >> k) & 1) == 1 && p != (1 << k)) acc = acc ^ cw[p];
      end
      cw[1 << k] = acc;
    end
    cw[0] = ^cw[CW_W-1:1];
    return cw;
  endfunction

  function automatic decodeRes_t eccDecode(input logic [CW_W-1:0] cw);
    decodeRes_t      res;
    logic [SYN_W-1:0] syn;
    logic [CW_W-1:0] fix;
    logic            par;
    int              n;
    syn = '0;
    for (int p = 1; p < CW_W; p++) begin
      if (cw[p]) syn = syn ^ SYN_W'(p);
    end
    par      = ^cw;
    fix      = cw;
    res.corr = 1'b0;
    res.unc  = 1'b0;
    if (par) begin
      if (syn == '0) begin
        res.corr = 1'b1;
      end else if (int'(syn) < CW_W) begin
        fix[syn] = ~fix[syn];
        res.corr = 1'b1;
      end else begin
        res.unc = 1'b1;
      end
    end else if (syn != '0) begin
      res.unc = 1'b1;
    end
    res.data = '0;
    n = 0;
    for (int p = 1; p < CW_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        res.data[n] = fix[p];
        n++;
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/ecc_ctrl.sv
module ecc_ctrl
  import ecc_mem_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int WIN_LOG2   = 13,
  parameter int WORDS_LOG2 = 10,
  localparam int BASE_W    = ADDR_W - WIN_LOG2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [BASE_W-1:0]     baseSel,
  input  logic                  req,
  input  logic                  we,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  clr,
  input  logic                  irqAck,
  input  logic                  errCorr,
  input  logic                  errUnc,
  output ctrlStrobes_t          strobes,
  output logic [WORDS_LOG2-1:0] idx,
  output logic                  ack,
  output logic                  ceFlag,
  output logic                  ueFlag,
  output logic                  irq
);

  logic [ADDR_W-1:0] baseAddr;
  logic [ADDR_W-1:0] offset;
  logic              hit;
  logic              rdPhase;

  assign baseAddr = {baseSel, {WIN_LOG2{1'b0}}};
  assign offset   = addr - baseAddr;
  assign hit      = (offset[ADDR_W-1:WORDS_LOG2] == '0);
  assign idx      = offset[WORDS_LOG2-1:0];

  always_comb begin
    strobes.wrEn = req & we & hit;
    strobes.rdEn = req & ~we & hit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ack     <= 1'b0;
      rdPhase <= 1'b0;
      ceFlag  <= 1'b0;
      ueFlag  <= 1'b0;
      irq     <= 1'b0;
    end else begin
      ack     <= req & hit;
      rdPhase <= strobes.rdEn;
      ceFlag  <= (rdPhase & errCorr) | (ceFlag & ~clr);
      ueFlag  <= (rdPhase & errUnc) | (ueFlag & ~clr);
      irq     <= (rdPhase & errUnc) | (irq & ~irqAck);
    end
  end

endmodule

// File: rtl/ecc_datapath.sv
module ecc_datapath
  import ecc_mem_pkg::*;
#(
  parameter int WORDS_LOG2 = 10,
  localparam int WORDS     = 1 << WORDS_LOG2
) (
  input  logic                  clk,
  input  ctrlStrobes_t          strobes,
  input  logic [WORDS_LOG2-1:0] idx,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [CW_W-1:0]       flipMask,
  output logic [DATA_W-1:0]     rdata,
  output logic                  errCorr,
  output logic                  errUnc
);

  logic [CW_W-1:0] store [WORDS];
  logic [CW_W-1:0] rawCw;
  decodeRes_t      dec;

  always_ff @(posedge clk) begin
    if (strobes.wrEn) store[idx] <= eccEncode(wdata) ^ flipMask;
    if (strobes.rdEn) rawCw <= store[idx];
  end

  always_comb begin
    dec     = eccDecode(rawCw);
    rdata   = dec.data;
    errCorr = dec.corr;
    errUnc  = dec.unc;
  end

endmodule

// File: rtl/ecc_mem_ctrl.sv
module ecc_mem_ctrl
  import ecc_mem_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int WIN_LOG2   = 13,
  parameter int WORDS_LOG2 = 10,
  localparam int BASE_W    = ADDR_W - WIN_LOG2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BASE_W-1:0] baseSel,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  input  logic [21:0]       flipMask,
  input  logic              clr,
  input  logic              irqAck,
  output logic              ack,
  output logic [15:0]       rdata,
  output logic              ceFlag,
  output logic              ueFlag,
  output logic              irq
);

  ctrlStrobes_t          strobes;
  logic [WORDS_LOG2-1:0] idx;
  logic                  errCorr;
  logic                  errUnc;

  ecc_ctrl #(
    .ADDR_W    (ADDR_W),
    .WIN_LOG2  (WIN_LOG2),
    .WORDS_LOG2(WORDS_LOG2)
  ) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .baseSel(baseSel),
    .req    (req),
    .we     (we),
    .addr   (addr),
    .clr    (clr),
    .irqAck (irqAck),
    .errCorr(errCorr),
    .errUnc (errUnc),
    .strobes(strobes),
    .idx    (idx),
    .ack    (ack),
    .ceFlag (ceFlag),
    .ueFlag (ueFlag),
    .irq    (irq)
  );

  ecc_datapath #(
    .WORDS_LOG2(WORDS_LOG2)
  ) dp_i (
    .clk     (clk),
    .strobes (strobes),
    .idx     (idx),
    .wdata   (wdata),
    .flipMask(flipMask),
    .rdata   (rdata),
    .errCorr (errCorr),
    .errUnc  (errUnc)
  );

endmodule

// File: rtl/ecc_mem_ctrl_chk.sv
module ecc_mem_ctrl_chk (
  input logic clk,
  input logic rstN,
  input logic req,
  input logic ack,
  input logic clr,
  input logic irqAck,
  input logic ceFlag,
  input logic ueFlag,
  input logic irq
);

  p_ack_needs_req_r1: assert property (@(posedge clk) disable iff (!rstN)
    ack |-> $past(req));

  p_ce_set_after_ack_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ceFlag) |-> $past(ack));

  p_irq_with_ue_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> ueFlag);

  p_ce_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ceFlag && !clr) |=> ceFlag);

  p_ue_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ueFlag && !clr) |=> ueFlag);

  p_irq_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !irqAck) |=> irq);

endmodule

bind ecc_mem_ctrl ecc_mem_ctrl_chk chk_i (
  .clk   (clk),
  .rstN  (rstN),
  .req   (req),
  .ack   (ack),
  .clr   (clr),
  .irqAck(irqAck),
  .ceFlag(ceFlag),
  .ueFlag(ueFlag),
  .irq   (irq)
);

// File: tb/ecc_mem_ctrl_tb_top.sv
module ecc_mem_ctrl_tb_top;

  localparam int WIN   = 8192;
  localparam int WORDS = 1024;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [6:0]  baseSel = 7'd3;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [19:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [21:0] flipMask = '0;
  logic        clr = 1'b0;
  logic        irqAck = 1'b0;
  logic        ack;
  logic [15:0] rdata;
  logic        ceFlag;
  logic        ueFlag;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  int          mData [int];
  logic [21:0] mMask [int];
  bit          eAck, eCe, eUe, eIrq;
  bit          pendV;
  int          pendCls;
  logic [15:0] pendData;

  ecc_mem_ctrl dut_i (
    .clk(clk), .rstN(rstN), .baseSel(baseSel), .req(req), .we(we),
    .addr(addr), .wdata(wdata), .flipMask(flipMask), .clr(clr),
    .irqAck(irqAck), .ack(ack), .rdata(rdata), .ceFlag(ceFlag),
    .ueFlag(ueFlag), .irq(irq)
  );

  always #2 clk = ~clk;

  function automatic int winOffset(input int a);
    return (a - int'(baseSel) * WIN) & 32'hFFFFF;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit rq, input bit w, input int a,
                      input logic [15:0] d, input logic [21:0] m,
                      input bit c, input bit ia);
    bit nCe, nUe, nIrq, hitNow, nPendV, prevCe, prevUe;
    int off, nCls;
    logic [15:0] nData;
    req = rq; we = w; addr = 20'(a); wdata = d; flipMask = m;
    clr = c; irqAck = ia;
    prevCe = eCe; prevUe = eUe;
    nCe  = (pendV && pendCls == 1) ? 1'b1 : (c ? 1'b0 : eCe);
    nUe  = (pendV && pendCls == 2) ? 1'b1 : (c ? 1'b0 : eUe);
    nIrq = (pendV && pendCls == 2) ? 1'b1 : (ia ? 1'b0 : eIrq);
    off    = winOffset(a);
    hitNow = rq && (off < WORDS);
    nPendV = hitNow && !w;
    nCls = 0; nData = '0;
    if (nPendV) begin
      nCls  = $countones(mMask[off]);
      nData = 16'(mData[off]);
    end
    if (hitNow && w) begin
      mData[off] = int'(d);
      mMask[off] = m;
    end
    @(posedge clk);
    @(negedge clk);
    eAck = hitNow; eCe = nCe; eUe = nUe; eIrq = nIrq;
    pendV = nPendV; pendCls = nCls; pendData = nData;
    chk(hitNow ? "R1" : "R2", "ack", 32'(ack), 32'(eAck));
    if (pendV && pendCls == 0) chk("R1", "rdata", 32'(rdata), 32'(pendData));
    if (pendV && pendCls == 1) chk("R3", "rdata corrected", 32'(rdata), 32'(pendData));
    chk(prevCe ? "R5" : "R3", "ceFlag", 32'(ceFlag), 32'(eCe));
    chk(prevUe ? "R5" : "R4", "ueFlag", 32'(ueFlag), 32'(eUe));
    chk("R6", "irq", 32'(irq), 32'(eIrq));
  endtask

  task automatic wr(input int a, input logic [15:0] d, input logic [21:0] m);
    step(1, 1, a, d, m, 0, 0);
  endtask

  task automatic rd(input int a);
    step(1, 0, a, '0, '0, 0, 0);
  endtask

  task automatic idle(input bit c, input bit ia);
    step(0, 0, 0, '0, '0, c, ia);
  endtask

  initial begin
    int base;
    eAck = 0; eCe = 0; eUe = 0; eIrq = 0; pendV = 0; pendCls = 0; pendData = '0;
    repeat (3) @(negedge clk);
    chk("R7", "ack in reset", 32'(ack), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R7", "ack", 32'(ack), 0);
    chk("R7", "ceFlag", 32'(ceFlag), 0);
    chk("R7", "ueFlag", 32'(ueFlag), 0);
    chk("R7", "irq", 32'(irq), 0);

    base = 3 * WIN;
    // R1: plain patterns at edges and middle of the window
    wr(base + 0, 16'h0000, '0);
    wr(base + 1, 16'hFFFF, '0);
    wr(base + WORDS - 1, 16'hA5A5, '0);
    wr(base + 500, 16'h1234, '0);
    rd(base + 0); rd(base + 1); rd(base + WORDS - 1); rd(base + 500);
    // back-to-back write then read of the same word
    wr(base + 7, 16'hC3E1, '0);
    rd(base + 7);

    // R2: just outside the window on both sides, with aliasing low bits
    wr(base - 1, 16'hDEAD, '0);
    wr(base + WORDS, 16'hBEEF, '0);
    wr(base + WORDS + WORDS - 1, 16'hFACE, '0);
    wr(4 * WIN, 16'h0BAD, '0);
    rd(base - 1);
    rd(base + 0); rd(base + WORDS - 1);
    idle(0, 0);

    // R3: one planted flip in each of the 22 codeword bits
    for (int b = 0; b < 22; b++) begin
      wr(base + 10 + b, 16'(b * 16'h1111) ^ 16'h5A3C, 22'(1) << b);
      rd(base + 10 + b);
      idle(0, 0);
      idle(0, 0);
      idle(1, 0);
    end
    idle(0, 0);

    // R4: two planted flips
    wr(base + 40, 16'h7777, 22'h000021);
    wr(base + 41, 16'h8001, 22'h020008);
    wr(base + 42, 16'h4242, 22'h300000);
    rd(base + 40);
    idle(0, 0);
    idle(0, 0);
    // R6: acknowledge drops irq, ue stays (R5)
    idle(0, 1);
    idle(0, 0);
    idle(1, 0);
    idle(0, 0);
    rd(base + 41);
    // R6: irqAck in the same cycle as a new report, set wins
    rd(base + 42);
    step(0, 0, 0, '0, '0, 0, 1);
    step(0, 0, 0, '0, '0, 1, 1);
    idle(0, 0);

    // R5: clear coinciding with a new correctable report, set wins
    rd(base + 12);
    step(0, 0, 0, '0, '0, 1, 0);
    idle(0, 0);
    idle(1, 0);
    idle(0, 0);

    // R2: move the window to the top of the address space
    baseSel = 7'd127;
    base = 127 * WIN;
    wr(base + 0, 16'h1357, '0);
    wr(base + WORDS - 1, 16'h2468, '0);
    rd(base + 0); rd(base + WORDS - 1);
    rd(3 * WIN + 1);
    rd(base + WORDS);
    idle(0, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule